// File: doc/BRIEF.md
# Run-Length Sample Slice Decoder

This block turns compressed logic-analyzer capture data back into a plain stream of 34-bit samples. Capture memory delivers its contents as slices of nine 32-bit words. The first eight words hold the low 32 bits of eight 36-bit entries. The ninth word carries the four most significant bits of all eight entries. The block gathers a whole slice and rebuilds each 36-bit entry. It decodes each entry as either a sample with a short repeat count or an extension of the repeat count. It then presents every sample on a valid/ready output port once per repeat.

A programmable limit caps the total number of samples emitted after reset. When the cap is reached mid-run, the rest of the run is dropped. Incoming slices are still drained after that point so that the supplier never stalls. Decoder state carries over from one slice to the next, so an extension entry may sit in the slice after the entry it extends.

Top module: `rle_slice_decoder`

## Requirements
- R1: A slice is accepted as nine words: eight low words, then the high-nibble word. After the ninth word is accepted, `in_ready` stays low until all eight entries of that slice have been consumed.
- R2: A word with `in_sos` high always starts a new slice at low-word position 0, discarding any partly collected slice. A word arriving without `in_sos` while no slice has been started is dropped.
- R3: Entry i (i = 0 for the first low word, up to 7) takes its bits 35:32 from bits [31-4i : 28-4i] of the high-nibble word. Its bits 31:0 are the i-th low word.
- R4: In data mode, entry bits 33:0 are the sample. If bit 35 is clear, that sample is emitted (bit 34 + 1) times, that is 1 or 2 times.
- R5: A data-mode entry with bit 35 set makes the following entry a length word L. Nothing from that sample is emitted until L arrives. The sample is then emitted (bit 34 + 1) + 2·L times, and the decoder returns to data mode.
- R6: The number of samples emitted since reset never exceeds `sample_limit`, and output stops exactly when that count is reached, even in the middle of a run. Later entries are still consumed, with no output.
- R7: Current sample, remaining repeats and data/length mode are kept across slice boundaries.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_sample` is unchanged in the next cycle.
- R9: A synchronous active-high reset clears the block: in the cycle after reset, `out_valid` is 0, `in_ready` is 1, the decoder is in data mode with nothing pending, and the emitted count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_limit | input | CNT_W | Maximum number of samples to emit after reset; change only during reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block accepts an input word |
| in_sos | input | 1 | Marks the first word of a slice |
| in_data | input | 32 | Input word |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Consumer takes the output sample |
| out_sample | output | 34 | Decoded sample value |

## Verification
On every cycle, the assertions check the following: the output hold rule under back-pressure; that the emitted count never passes the limit; that no sample appears while the decoder waits for a length word; that an entry is never taken in the same cycle that a sample leaves; and that a slice only completes on an accepted word. Two things only the bench scenarios can show: that each rebuilt entry picks the correct nibble, and that run lengths add up correctly, including an extension split across a slice boundary. These need a reference model fed the same entries, as do dropping of unstarted words, restart on a mid-slice start marker, and the exact truncation point at the limit.

// File: rtl/rle_slice_pkg.sv
package rle_slice_pkg;

  localparam int LOW_W    = 32;
  localparam int NIB_W    = 4;
  localparam int SLICE_N  = 8;
  localparam int ENT_W    = LOW_W + NIB_W;
  localparam int SMP_W    = 34;
  localparam int BIT_REP  = SMP_W;
  localparam int BIT_EXT  = SMP_W + 1;
  localparam int IDX_BITS = $clog2(SLICE_N);
  localparam int RUN_W    = ENT_W + 2;

  typedef enum logic {
    MODE_DATA = 1'b0,
    MODE_LEN  = 1'b1
  } rle_mode_e;

  // Upper nibble of entry idx: entry 0 lives in the most significant nibble.
  function automatic logic [NIB_W-1:0] top_nibble(input logic [LOW_W-1:0] hw,
                                                  input logic [IDX_BITS-1:0] idx);
    int unsigned sh;
    sh = (SLICE_N - 1 - int'(idx)) * NIB_W;
    return NIB_W'(hw >> sh);
  endfunction

  function automatic logic [ENT_W-1:0] build_entry(input logic [LOW_W-1:0] lo,
                                                   input logic [LOW_W-1:0] hw,
                                                   input logic [IDX_BITS-1:0] idx);
    return {top_nibble(hw, idx), lo};
  endfunction

  // Inline repeat count of a data entry: 1 or 2.
  function automatic logic [1:0] base_run(input logic [ENT_W-1:0] ent);
    return {1'b0, ent[BIT_REP]} + 2'd1;
  endfunction

  // Run length after a length word has been applied.
  function automatic logic [RUN_W-1:0] ext_run(input logic [1:0] pend,
                                               input logic [ENT_W-1:0] ent);
    return RUN_W'(pend) + (RUN_W'(ent) << 1);
  endfunction

endpackage

// File: rtl/rle_slice_buf.sv
module rle_slice_buf
  import rle_slice_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_sos,
  input  logic [LOW_W-1:0] in_data,
  output logic             in_ready,
  output logic             ent_valid,
  output logic [ENT_W-1:0] ent_data,
  input  logic             ent_take,
  output logic             slice_full
);

  localparam int WR_W = $clog2(SLICE_N + 1);

  logic [LOW_W-1:0]    lo_q [SLICE_N];
  logic [LOW_W-1:0]    hi_q;
  logic [WR_W-1:0]     wr_q;
  logic [IDX_BITS-1:0] rd_q;
  logic                full_q;
  logic                accept;

  assign accept = in_valid && !full_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q   <= '0;
      rd_q   <= '0;
      full_q <= 1'b0;
      hi_q   <= '0;
    end else begin
      if (accept) begin
        if (in_sos) begin
          lo_q[0] <= in_data;
          wr_q    <= WR_W'(1);
        end else if (wr_q == '0) begin
          wr_q <= '0;
        end else if (wr_q == WR_W'(SLICE_N)) begin
          hi_q   <= in_data;
          full_q <= 1'b1;
          wr_q   <= '0;
        end else begin
          lo_q[wr_q[IDX_BITS-1:0]] <= in_data;
          wr_q <= wr_q + WR_W'(1);
        end
      end
      if (ent_take) begin
        if (rd_q == IDX_BITS'(SLICE_N - 1)) begin
          rd_q   <= '0;
          full_q <= 1'b0;
        end else begin
          rd_q <= rd_q + IDX_BITS'(1);
        end
      end
    end
  end

  assign in_ready   = !full_q;
  assign ent_valid  = full_q;
  assign ent_data   = build_entry(lo_q[rd_q], hi_q, rd_q);
  assign slice_full = full_q;

endmodule

// File: rtl/rle_run_engine.sv
module rle_run_engine
  import rle_slice_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ent_valid,
  input  logic [ENT_W-1:0] ent_data,
  output logic             ent_take,
  input  logic             out_fire,
  input  logic             lim_hit,
  output logic             run_active,
  output logic [SMP_W-1:0] sample,
  output logic             len_wait
);

  rle_mode_e        mode_q;
  logic [SMP_W-1:0] sample_q;
  logic [RUN_W-1:0] run_q;
  logic [1:0]       pend_q;
  logic             run_idle;

  assign run_idle = (run_q == '0);
  assign ent_take = ent_valid && (run_idle || lim_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MODE_DATA;
      sample_q <= '0;
      run_q    <= '0;
      pend_q   <= '0;
    end else if (ent_take) begin
      if (lim_hit) begin
        run_q  <= '0;
        mode_q <= MODE_DATA;
      end else if (mode_q == MODE_DATA) begin
        sample_q <= ent_data[SMP_W-1:0];
        if (ent_data[BIT_EXT]) begin
          mode_q <= MODE_LEN;
          pend_q <= base_run(ent_data);
        end else begin
          run_q <= RUN_W'(base_run(ent_data));
        end
      end else begin
        run_q  <= ext_run(pend_q, ent_data);
        mode_q <= MODE_DATA;
      end
    end else if (out_fire) begin
      run_q <= run_q - RUN_W'(1);
    end
  end

  assign run_active = !run_idle;
  assign sample     = sample_q;
  assign len_wait   = (mode_q == MODE_LEN);

endmodule

// File: rtl/rle_limit_gate.sv
module rle_limit_gate #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] limit,
  input  logic             run_active,
  input  logic             out_ready,
  output logic             out_valid,
  output logic             out_fire,
  output logic             lim_hit
);

  logic [CNT_W-1:0] cnt_q;

  assign lim_hit   = (cnt_q >= limit);
  assign out_valid = run_active && !lim_hit;
  assign out_fire  = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (out_fire) cnt_q <= cnt_q + CNT_W'(1);
  end

endmodule

// File: rtl/rle_slice_decoder.sv
module rle_slice_decoder
  import rle_slice_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] sample_limit,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_sos,
  input  logic [31:0]      in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [33:0]      out_sample
);

  logic             ent_valid;
  logic [ENT_W-1:0] ent_data;
  logic             ent_take;
  logic             buf_full;
  logic             out_fire;
  logic             lim_hit;
  logic             run_active;
  logic             len_wait;
  logic [SMP_W-1:0] smp;

  rle_slice_buf u_buf (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_sos     (in_sos),
    .in_data    (in_data),
    .in_ready   (in_ready),
    .ent_valid  (ent_valid),
    .ent_data   (ent_data),
    .ent_take   (ent_take),
    .slice_full (buf_full)
  );

  rle_run_engine u_eng (
    .clk        (clk),
    .rst        (rst),
    .ent_valid  (ent_valid),
    .ent_data   (ent_data),
    .ent_take   (ent_take),
    .out_fire   (out_fire),
    .lim_hit    (lim_hit),
    .run_active (run_active),
    .sample     (smp),
    .len_wait   (len_wait)
  );

  rle_limit_gate #(.CNT_W(CNT_W)) u_gate (
    .clk        (clk),
    .rst        (rst),
    .limit      (sample_limit),
    .run_active (run_active),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .out_fire   (out_fire),
    .lim_hit    (lim_hit)
  );

  assign out_sample = smp;

endmodule

// File: rtl/rle_slice_decoder_chk.sv
module rle_slice_decoder_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] sample_limit,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [33:0]      out_sample,
  input logic             buf_full,
  input logic             ent_take,
  input logic             len_wait
);

  // Independent tally of handshakes at the output port.
  logic [CNT_W-1:0] seen_q;
  always_ff @(posedge clk) begin
    if (rst) seen_q <= '0;
    else if (out_valid && out_ready) seen_q <= seen_q + CNT_W'(1);
  end

  // R1: a slice becomes complete only on a cycle where a word was accepted
  p_fill_on_accept_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(buf_full) |-> $past(in_valid && in_ready));

  // R4: an entry is never taken while a sample leaves
  p_take_idle_r4: assert property (@(posedge clk) disable iff (rst)
    ent_take |-> !(out_valid && out_ready));

  // R5: no sample is offered while a length word is awaited
  p_len_wait_r5: assert property (@(posedge clk) disable iff (rst)
    len_wait |-> !out_valid);

  // R6: an offered sample always stays inside the limit
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (seen_q < sample_limit));

  // R8: back-pressure holds the offered sample
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sample)));

  // R9: reset leaves the ports idle and ready
  p_reset_state_r9: assert property (@(posedge clk)
    rst |=> (!out_valid && in_ready));

endmodule

bind rle_slice_decoder rle_slice_decoder_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .sample_limit (sample_limit),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_sample   (out_sample),
  .buf_full     (buf_full),
  .ent_take     (ent_take),
  .len_wait     (len_wait)
);

// File: tb/rle_slice_decoder_tb_top.sv
`timescale 1ns/1ps
module rle_slice_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] lim = 32'hFFFF_FFFF;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_sos = 1'b0;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [33:0] out_sample;

  always #2 clk = ~clk;

  rle_slice_decoder dut_i (
    .clk(clk), .rst(rst), .sample_limit(lim),
    .in_valid(in_valid), .in_ready(in_ready), .in_sos(in_sos), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_sample(out_sample)
  );

  int n_chk = 0;
  int n_fail = 0;

  // Reference model state
  logic [33:0] exp_q[$];
  longint      m_count = 0;
  longint      pushed_total = 0;
  bit          m_len = 0;
  longint      m_pend = 0;
  logic [33:0] m_smp = '0;
  int          ready_mode = 0;   // 0 random, 1 held low, 2 held high
  logic [35:0] ents_b [8];

  bit          prev_v = 0;
  bit          prev_r = 0;
  logic [33:0] prev_s = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [35:0] mk(input logic [33:0] s, input bit rep2, input bit ext);
    return {ext, rep2, s};
  endfunction

  function automatic void model_push(input logic [35:0] e);
    longint n;
    if (!m_len) begin
      m_smp = e[33:0];
      n = e[34] ? 2 : 1;
      if (e[35]) begin
        m_len  = 1;
        m_pend = n;
        n = 0;
      end
    end else begin
      n = m_pend + 2 * longint'(e);
      m_len = 0;
    end
    for (longint k = 0; k < n; k++) exp_q.push_back(m_smp);
    pushed_total += n;
  endfunction

  task automatic send_word(input logic [31:0] d, input bit s);
    in_valid = 1'b1;
    in_data  = d;
    in_sos   = s;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_sos   = 1'b0;
  endtask

  // Split entries into eight low words and one nibble word, feed them.
  task automatic send_entries();
    logic [31:0] hw;
    hw = '0;
    for (int i = 0; i < 8; i++) begin
      hw = hw | (32'(ents_b[i][35:32]) << (4 * (7 - i)));
      model_push(ents_b[i]);
    end
    for (int i = 0; i < 8; i++) send_word(ents_b[i][31:0], i == 0);
    send_word(hw, 1'b0);
  endtask

  task automatic do_reset(input logic [31:0] new_lim);
    rst = 1'b1;
    in_valid = 1'b0;
    in_sos = 1'b0;
    lim = new_lim;
    repeat (3) @(negedge clk);
    exp_q.delete();
    m_count = 0; pushed_total = 0; m_len = 0; m_pend = 0;
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R9", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R9", "in_ready after reset", in_ready, 1);
  endtask

  task automatic drain(input string req);
    int waited;
    longint want;
    waited = 0;
    while (!(exp_q.size() == 0 || m_count >= longint'(lim)) && waited < 3000) begin
      @(negedge clk);
      waited++;
    end
    repeat (6) @(negedge clk);
    want = (pushed_total < longint'(lim)) ? pushed_total : longint'(lim);
    chk(m_count == want, req, "emitted count", m_count, want);
    chk(out_valid == 1'b0, req, "idle after drain", out_valid, 0);
  endtask

  // Cycle monitor: compares the port against the model on every clock.
  always @(negedge clk) begin
    bit r;
    if (rst) begin
      prev_v = 0;
    end else begin
      case (ready_mode)
        1:       r = 1'b0;
        2:       r = 1'b1;
        default: r = ($urandom % 4) != 0;
      endcase
      out_ready = r;
      if (prev_v && !prev_r)
        chk(out_valid && (out_sample == prev_s), "R8", "held sample",
            longint'(out_sample), longint'(prev_s));
      if (out_valid) begin
        chk(m_count < longint'(lim) && exp_q.size() > 0, "R6", "valid allowed",
            m_count, longint'(lim));
        if (exp_q.size() > 0) begin
          chk(out_sample == exp_q[0], "R3 R4 R5 R7", "sample value",
              longint'(out_sample), longint'(exp_q[0]));
          if (r) begin
            void'(exp_q.pop_front());
            m_count++;
          end
        end
      end
      prev_v = out_valid;
      prev_r = r;
      prev_s = out_sample;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    @(negedge clk);
    // R9: reset state
    do_reset(32'hFFFF_FFFF);

    // R3, R4: plain data entries with distinct top nibbles
    for (int i = 0; i < 8; i++)
      ents_b[i] = mk({2'(i), 32'hA500_0000 ^ (32'h0101_0101 * i)}, i[0], 1'b0);
    send_entries();
    drain("R4");

    // R5, R7: extension inside a slice and across a slice boundary
    for (int i = 0; i < 8; i++) ents_b[i] = mk(34'h1_0000_0100 + 34'(i), 1'b0, 1'b0);
    ents_b[2] = mk(34'h2_1234_5678, 1'b1, 1'b1);
    ents_b[3] = 36'd3;                          // run 2 + 6
    ents_b[7] = mk(34'h3_CAFE_0007, 1'b0, 1'b1); // length in next slice
    send_entries();
    for (int i = 0; i < 8; i++) ents_b[i] = mk(34'h0_0000_0200 + 34'(i), 1'b1, 1'b0);
    ents_b[0] = 36'd5;                          // run 1 + 10
    send_entries();
    drain("R7");

    // R2: unstarted words dropped, mid-slice start marker restarts
    send_word(32'hDEAD_0001, 1'b0);
    send_word(32'hDEAD_0002, 1'b0);
    send_word(32'hDEAD_0003, 1'b0);
    send_word(32'hBEEF_0000, 1'b1);
    for (int i = 1; i < 5; i++) send_word(32'hBEEF_0000 + 32'(i), 1'b0);
    for (int i = 0; i < 8; i++) ents_b[i] = mk(34'h2_0F0F_0000 + 34'(i), 1'b0, 1'b0);
    send_entries();
    drain("R2");

    // R6: limit truncates a long run
    do_reset(32'd5);
    for (int i = 0; i < 8; i++) ents_b[i] = mk(34'h1_5555_0000 + 34'(i), 1'b0, 1'b0);
    ents_b[0] = mk(34'h3_0000_00AA, 1'b0, 1'b1);
    ents_b[1] = 36'd3;                          // run 7, only 5 allowed
    send_entries();
    drain("R6");
    for (int i = 0; i < 8; i++) ents_b[i] = mk(34'h0_7777_0000 + 34'(i), 1'b1, 1'b0);
    send_entries();                             // still accepted after the limit
    drain("R6");
    chk(m_count == 5, "R6", "total after limit", m_count, 5);

    // R1, R8: buffered slice blocks input while output is stalled
    do_reset(32'hFFFF_FFFF);
    ready_mode = 1;
    for (int i = 0; i < 8; i++) ents_b[i] = mk(34'h1_0000_3000 + 34'(i), 1'b1, 1'b0);
    send_entries();
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b0, "R1", "in_ready while slice held", in_ready, 0);
    chk(out_valid == 1'b1, "R8", "valid held under stall", out_valid, 1);
    ready_mode = 0;
    drain("R1");
    chk(in_ready == 1'b1, "R1", "in_ready after slice consumed", in_ready, 1);

    summary();
    $finish;
  end

endmodule